// File: doc/BRIEF.md
# Flash Program/Erase Host Controller

This block sits on the host side of a byte-wide parallel flash bus. It carries out single-byte program and 256-byte sector erase operations on a device that has already been unprotected. It then watches the device until the operation is finished. A request gives the operation kind, an address, a data byte and a completion-detection mode. The controller runs the two-write command sequence, with chip-enable, write-enable and output-enable strobes whose active and recovery widths are parameters counted in clock cycles. It then polls the target location until the chosen completion rule is met.

Three completion rules are offered:

- Watch bit 7 for the expected polarity.
- Watch bit 6 for two successive reads that agree.
- Watch for two whole bytes in a row that are identical.

A read that looks complete can coincide with the device finishing its internal cycle. Any apparent success is therefore checked with two further reads that must both reproduce the candidate byte. If the operation does not finish within a per-operation cycle budget, the controller writes the abort command and reports an error. In bit-7 mode it also compares the settled byte against the value the request expects.

Top module: `flash_pe_ctrl`

## Requirements
- R1: A request with `req_erase`=0 issues exactly two bus writes: data 10h, then `req_data` at `req_addr`.
- R2: A request with `req_erase`=1 issues exactly two bus writes: data 20h, then D0h at `req_addr` (the sector is `req_addr` bits above bit 7).
- R3: Every write holds `fl_we_n` and `fl_ce_n` low for exactly WR_LOW_CYC cycles. Between any two bus cycles `fl_ce_n` stays high for at least WR_HIGH_CYC cycles. `fl_we_n` and `fl_oe_n` are never low together.
- R4: With `poll_mode`=0 (bit-7 polling), a read counts as a completion candidate when its bit 7 equals bit 7 of the expected byte. The expected byte is `req_data` for a program and FFh for an erase.
- R5: With `poll_mode`=1 (bit-6 toggle), a read counts as a candidate when its bit 6 equals bit 6 of the preceding poll read of the same operation.
- R6: With `poll_mode`=2 (repeat read), a read counts as a candidate when all 8 bits equal the preceding poll read of the same operation.
- R7: After a candidate, the location is read twice more. `done` is raised only if both reads equal the candidate; otherwise polling resumes.
- R8: If the poll phase lasts PROG_TMO_CYC cycles (program) or ERASE_TMO_CYC cycles (erase) without a confirmed completion, the controller writes FFh to the target address and then raises `done` with `error`=1.
- R9: With `poll_mode`=0, a confirmed byte that differs from the expected byte raises `error` together with `done`. In the other modes, a confirmed completion reports `error`=0.
- R10: After reset all strobes are high and `busy` is 0. `done` is a one-cycle pulse. A `req_valid` raised while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operation (taken when not busy) |
| req_erase | input | 1 | 0 = byte program, 1 = sector erase |
| req_addr | input | AW | Target byte / sector address |
| req_data | input | 8 | Byte to program |
| poll_mode | input | 2 | 0 bit-7, 1 bit-6 toggle, 2 repeat read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Valid with done: timeout abort or data mismatch |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Write data toward flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Read data from flash |

## Verification
The bench builds the controller with a 12-bit address, a 3-cycle write pulse, a 2-cycle recovery, a 2-cycle read and timeout budgets of 400 and 800 cycles. These small values make timeout aborts reachable in a few hundred cycles. The bench can then sweep every poll mode against both operations and against four device behaviours: a clean finish, a single premature valid-looking read during the busy phase, a device that never finishes, and a device that settles on a wrong byte. A behavioural flash model measures strobe widths and gaps on the bus.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [1:0] {
    PM_BIT7   = 2'd0,
    PM_TOGGLE = 2'd1,
    PM_REPEAT = 2'd2
  } poll_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_RECOV  = 2'd2
  } bus_phase_e;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_SETUP = 4'd1,
    ST_EXEC  = 4'd2,
    ST_POLL  = 4'd3,
    ST_CONF1 = 4'd4,
    ST_CONF2 = 4'd5,
    ST_ABORT = 4'd6,
    ST_FIN   = 4'd7
  } ctrl_state_e;

  localparam logic [7:0] CMD_PROG_SETUP  = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_ABORT       = 8'hFF;
  localparam logic [7:0] ERASED_BYTE     = 8'hFF;

endpackage

// File: rtl/flash_bus_seq.sv
module flash_bus_seq
  import flash_pe_pkg::*;
#(
  parameter int AW      = 19,
  parameter int WR_LOW  = 5,
  parameter int WR_HIGH = 3,
  parameter int RD_LOW  = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [7:0]    dq_in,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    dq_out,
  output logic          dq_oe,
  output logic          cyc_done,
  output logic [7:0]    rdata
);

  localparam int MAXA = (WR_LOW > RD_LOW) ? WR_LOW : RD_LOW;
  localparam int MAXC = (MAXA > WR_HIGH) ? MAXA : WR_HIGH;
  localparam int CW   = $clog2(MAXC + 1);

  bus_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    data_q, data_d;
  logic [7:0]    rdata_q, rdata_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    data_d  = data_q;
    rdata_d = rdata_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ACTIVE;
          cnt_d   = wr ? CW'(WR_LOW - 1) : CW'(RD_LOW - 1);
          wr_d    = wr;
          addr_d  = addr;
          data_d  = wdata;
        end
      end
      PH_ACTIVE: begin
        if (cnt_q == '0) begin
          phase_d = PH_RECOV;
          cnt_d   = CW'(WR_HIGH - 1);
          if (!wr_q) rdata_d = dq_in;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RECOV: begin
        if (cnt_q == '0) phase_d = PH_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      rdata_q <= rdata_d;
    end
  end

  assign ce_n     = (phase_q != PH_ACTIVE);
  assign we_n     = !((phase_q == PH_ACTIVE) && wr_q);
  assign oe_n     = !((phase_q == PH_ACTIVE) && !wr_q);
  assign dq_oe    = wr_q && (phase_q != PH_IDLE);
  assign bus_addr = addr_q;
  assign dq_out   = data_q;
  assign cyc_done = (phase_q == PH_RECOV) && (cnt_q == '0);
  assign rdata    = rdata_q;

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
  import flash_pe_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [7:0] rd,
  input  logic [7:0] prev,
  input  logic       have_prev,
  input  logic [7:0] expect_byte,
  output logic       hit
);

  always_comb begin
    unique case (mode)
      PM_BIT7:   hit = (rd[7] == expect_byte[7]);
      PM_TOGGLE: hit = have_prev && (rd[6] == prev[6]);
      default:   hit = have_prev && (rd == prev);
    endcase
  end

endmodule

// File: rtl/flash_tmo_timer.sv
module flash_tmo_timer #(
  parameter int PROG_LIM  = 1750,
  parameter int ERASE_LIM = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic sel_erase,
  output logic expired
);

  localparam int MAXL = (PROG_LIM > ERASE_LIM) ? PROG_LIM : ERASE_LIM;
  localparam int TW   = $clog2(MAXL + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] limit;
  logic          cnt_en;

  assign limit   = sel_erase ? TW'(ERASE_LIM) : TW'(PROG_LIM);
  assign expired = (cnt_q >= limit);
  assign cnt_en  = clr || (en && !expired);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int AW            = 19,
  parameter int WR_LOW_CYC    = 5,
  parameter int WR_HIGH_CYC   = 3,
  parameter int RD_LOW_CYC    = 13,
  parameter int PROG_TMO_CYC  = 1750,
  parameter int ERASE_TMO_CYC = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_erase,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic [1:0]    poll_mode,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  ctrl_state_e   st_q, st_d;
  logic          erase_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [1:0]    mode_q;
  logic [7:0]    prev_q, prev_d;
  logic          have_q, have_d;
  logic [7:0]    cand_q, cand_d;
  logic          err_q, err_d;
  logic          infl_q, infl_d;
  logic          req_load;

  logic          bus_start, bus_wr, bus_active, cyc_done;
  logic [7:0]    bus_wdata, rdata, expect_byte;
  logic          hit, tmo, tmo_clr, tmo_en, cand_match;

  assign expect_byte = erase_q ? ERASED_BYTE : data_q;
  assign cand_match  = (rdata == cand_q);
  assign req_load    = (st_q == ST_IDLE) && req_valid;

  always_comb begin
    st_d      = st_q;
    prev_d    = prev_q;
    have_d    = have_q;
    cand_d    = cand_q;
    err_d     = err_q;
    bus_wr    = 1'b0;
    bus_wdata = CMD_ABORT;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d   = ST_SETUP;
          have_d = 1'b0;
          err_d  = 1'b0;
        end
      end
      ST_SETUP: begin
        bus_wr    = 1'b1;
        bus_wdata = erase_q ? CMD_ERASE_SETUP : CMD_PROG_SETUP;
        if (cyc_done) st_d = ST_EXEC;
      end
      ST_EXEC: begin
        bus_wr    = 1'b1;
        bus_wdata = erase_q ? CMD_ERASE_GO : data_q;
        if (cyc_done) st_d = ST_POLL;
      end
      ST_POLL: begin
        if (cyc_done) begin
          if (hit) begin
            cand_d = rdata;
            st_d   = ST_CONF1;
          end else if (tmo) begin
            st_d = ST_ABORT;
          end else begin
            prev_d = rdata;
            have_d = 1'b1;
          end
        end
      end
      ST_CONF1, ST_CONF2: begin
        if (cyc_done) begin
          if (cand_match) begin
            if (st_q == ST_CONF1) begin
              st_d = ST_CONF2;
            end else begin
              st_d  = ST_FIN;
              err_d = (mode_q == PM_BIT7) && (rdata != expect_byte);
            end
          end else if (tmo) begin
            st_d = ST_ABORT;
          end else begin
            prev_d = rdata;
            have_d = 1'b1;
            st_d   = ST_POLL;
          end
        end
      end
      ST_ABORT: begin
        bus_wr    = 1'b1;
        bus_wdata = CMD_ABORT;
        if (cyc_done) begin
          err_d = 1'b1;
          st_d  = ST_FIN;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign bus_active = (st_q == ST_SETUP) || (st_q == ST_EXEC) || (st_q == ST_POLL) ||
                      (st_q == ST_CONF1) || (st_q == ST_CONF2) || (st_q == ST_ABORT);
  assign bus_start  = bus_active && !infl_q;

  always_comb begin
    infl_d = infl_q;
    if (bus_start)     infl_d = 1'b1;
    else if (cyc_done) infl_d = 1'b0;
  end

  assign tmo_clr = (st_q == ST_EXEC);
  assign tmo_en  = (st_q == ST_POLL) || (st_q == ST_CONF1) || (st_q == ST_CONF2);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q   <= ST_IDLE;
      prev_q <= '0;
      have_q <= 1'b0;
      cand_q <= '0;
      err_q  <= 1'b0;
      infl_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      prev_q <= prev_d;
      have_q <= have_d;
      cand_q <= cand_d;
      err_q  <= err_d;
      infl_q <= infl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      mode_q  <= '0;
    end else if (req_load) begin
      erase_q <= req_erase;
      addr_q  <= req_addr;
      data_q  <= req_data;
      mode_q  <= poll_mode;
    end
  end

  flash_bus_seq #(
    .AW(AW), .WR_LOW(WR_LOW_CYC), .WR_HIGH(WR_HIGH_CYC), .RD_LOW(RD_LOW_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (bus_start),
    .wr       (bus_wr),
    .addr     (addr_q),
    .wdata    (bus_wdata),
    .dq_in    (fl_dq_in),
    .ce_n     (fl_ce_n),
    .oe_n     (fl_oe_n),
    .we_n     (fl_we_n),
    .bus_addr (fl_addr),
    .dq_out   (fl_dq_out),
    .dq_oe    (fl_dq_oe),
    .cyc_done (cyc_done),
    .rdata    (rdata)
  );

  flash_poll_eval u_eval (
    .mode        (mode_q),
    .rd          (rdata),
    .prev        (prev_q),
    .have_prev   (have_q),
    .expect_byte (expect_byte),
    .hit         (hit)
  );

  flash_tmo_timer #(
    .PROG_LIM(PROG_TMO_CYC), .ERASE_LIM(ERASE_TMO_CYC)
  ) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .clr       (tmo_clr),
    .en        (tmo_en),
    .sel_erase (erase_q),
    .expired   (tmo)
  );

  assign busy  = (st_q != ST_IDLE);
  assign done  = (st_q == ST_FIN);
  assign error = (st_q == ST_FIN) && err_q;

endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter int WR_LOW  = 5,
  parameter int WR_HIGH = 3
) (
  input logic clk,
  input logic rst_n,
  input logic fl_ce_n,
  input logic fl_oe_n,
  input logic fl_we_n,
  input logic busy,
  input logic done
);

  logic [7:0] low_run_q;
  logic [7:0] high_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q  <= '0;
      high_run_q <= 8'hFF;
    end else begin
      low_run_q  <= fl_we_n ? 8'd0 : low_run_q + 8'd1;
      if (!fl_ce_n)               high_run_q <= '0;
      else if (high_run_q != 8'hFF) high_run_q <= high_run_q + 8'd1;
    end
  end

  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)); // R3

  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (low_run_q == 8'(WR_LOW))); // R3

  AST_CE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_ce_n) |-> (high_run_q >= 8'(WR_HIGH))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_ce_n && fl_we_n && fl_oe_n)); // R10

endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(
  .WR_LOW(WR_LOW_CYC), .WR_HIGH(WR_HIGH_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fl_ce_n (fl_ce_n),
  .fl_oe_n (fl_oe_n),
  .fl_we_n (fl_we_n),
  .busy    (busy),
  .done    (done)
);

// File: tb/tb_flash_pe_ctrl.sv
module tb_flash_pe_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int WL = 3;
  localparam int WH = 2;
  localparam int RL = 2;
  localparam int PTMO = 400;
  localparam int ETMO = 800;
  localparam int PBUSY = 60;
  localparam int EBUSY = 150;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_erase;
  logic [AW-1:0] req_addr;
  logic [7:0] req_data;
  logic [1:0] poll_mode;
  logic busy, done, error;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_out, fl_dq_in;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pe_ctrl #(
    .AW(AW), .WR_LOW_CYC(WL), .WR_HIGH_CYC(WH), .RD_LOW_CYC(RL),
    .PROG_TMO_CYC(PTMO), .ERASE_TMO_CYC(ETMO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .poll_mode(poll_mode),
    .busy(busy), .done(done), .error(error),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  // ---------------- behavioural flash model ----------------
  logic [7:0] mem [512];
  bit  cfg_glitch, cfg_stuck, cfg_bad;
  int  pend, busy_cnt, busy_rd, we_run, ce_gap, width_bad, wcount;
  bit  stuck_q, is_erase, tog, seen_cyc;
  logic [8:0] tgt;
  logic [7:0] fin;
  logic prev_we, prev_oe, prev_ce;
  logic [AW-1:0] wr_a [128];
  logic [7:0]    wr_d [128];

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    pend = 0; busy_cnt = 0; busy_rd = 0; we_run = 0; ce_gap = 0;
    width_bad = 0; wcount = 0; tog = 0; seen_cyc = 0; stuck_q = 0;
    is_erase = 0; tgt = '0; fin = '0;
    prev_we = 1; prev_oe = 1; prev_ce = 1;
    cfg_glitch = 0; cfg_stuck = 0; cfg_bad = 0;
  end

  always_comb begin
    if (busy_cnt > 0 && fl_addr[8:0] == tgt) begin
      if (cfg_glitch && busy_rd == 2) fl_dq_in = fin;
      else                            fl_dq_in = {~fin[7], tog, 6'b0};
    end else begin
      fl_dq_in = mem[fl_addr[8:0]];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n) begin
        we_run++;
      end else if (!prev_we) begin
        if (we_run != WL) width_bad++;
        if (!fl_dq_oe) width_bad++;
        we_run = 0;
        wr_a[wcount[6:0]] = fl_addr;
        wr_d[wcount[6:0]] = fl_dq_out;
        wcount++;
        if (fl_dq_out == 8'hFF) begin
          pend = 0; busy_cnt = 0;
        end else if (pend == 1) begin
          fin = cfg_bad ? (fl_dq_out ^ 8'h01) : fl_dq_out;
          tgt = fl_addr[8:0]; is_erase = 0; busy_cnt = PBUSY;
          stuck_q = cfg_stuck; busy_rd = 0; pend = 0;
        end else if (pend == 2 && fl_dq_out == 8'hD0) begin
          fin = 8'hFF; tgt = fl_addr[8:0]; is_erase = 1; busy_cnt = EBUSY;
          stuck_q = cfg_stuck; busy_rd = 0; pend = 0;
        end else if (fl_dq_out == 8'h10) pend = 1;
        else if (fl_dq_out == 8'h20)     pend = 2;
        else                             pend = 0;
      end
      if (fl_ce_n) ce_gap++;
      else begin
        if (prev_ce && seen_cyc && ce_gap < WH) width_bad++;
        seen_cyc = 1; ce_gap = 0;
      end
      if (fl_oe_n && !prev_oe) begin
        tog = ~tog;
        if (busy_cnt > 0) busy_rd++;
      end
      if (busy_cnt > 0 && !stuck_q) begin
        busy_cnt--;
        if (busy_cnt == 0) begin
          if (is_erase) for (int i = 0; i < 256; i++) mem[{tgt[8], i[7:0]}] = 8'hFF;
          else          mem[tgt] = fin;
        end
      end
    end
    prev_we = fl_we_n; prev_oe = fl_oe_n; prev_ce = fl_ce_n;
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string mode_req(input int m);
    if (m == 0) return "R4";
    if (m == 1) return "R5";
    return "R6";
  endfunction

  task automatic run(input bit er, input int m, input int scen, input logic [7:0] d,
                     input logic [AW-1:0] a);
    int wc0, wb0, t, nw;
    bit exp_err, seen;
    logic [7:0] exp_mem;
    cfg_glitch = (scen == 1);
    cfg_stuck  = (scen == 2);
    cfg_bad    = (scen == 3);
    if (er) mem[{a[8], 8'h5A}] = 8'h00;
    wc0 = wcount; wb0 = width_bad;
    @(negedge clk);
    req_valid = 1; req_erase = er; req_addr = a; req_data = d; poll_mode = 2'(m);
    @(negedge clk);
    req_valid = 0;
    t = 1; seen = 0;
    while (t < 5000 && !seen) begin
      if (t == 15) begin
        req_valid = 1; req_data = ~d; req_addr = a ^ 12'h0F0; req_erase = ~er;
      end else req_valid = 0;
      if (done) seen = 1;
      else begin @(negedge clk); t++; end
    end
    req_valid = 0;
    chk(seen, "R10 done seen", seen, 1);
    exp_err = (scen == 2) || (scen == 3 && m == 0);
    chk(error == exp_err, (scen == 2) ? "R8 error" : (scen == 3) ? "R9 error" : mode_req(m),
        error, exp_err);
    nw = wcount - wc0;
    chk(nw == ((scen == 2) ? 3 : 2), "R10 write count", nw, (scen == 2) ? 3 : 2);
    chk(wr_d[wc0[6:0]] == (er ? 8'h20 : 8'h10), er ? "R2 setup" : "R1 setup",
        wr_d[wc0[6:0]], er ? 8'h20 : 8'h10);
    chk(wr_d[(wc0 + 1) % 128] == (er ? 8'hD0 : d) && wr_a[(wc0 + 1) % 128] == a,
        er ? "R2 execute" : "R1 execute", wr_d[(wc0 + 1) % 128], er ? 8'hD0 : d);
    if (scen == 2) begin
      chk(wr_d[(wc0 + 2) % 128] == 8'hFF && wr_a[(wc0 + 2) % 128] == a, "R8 abort write",
          wr_d[(wc0 + 2) % 128], 8'hFF);
      chk(t >= (er ? ETMO : PTMO) && t <= (er ? ETMO : PTMO) + 60, "R8 timeout span", t,
          er ? ETMO : PTMO);
    end else begin
      exp_mem = er ? 8'hFF : ((scen == 3) ? (d ^ 8'h01) : d);
      chk(mem[a[8:0]] == exp_mem, mode_req(m), mem[a[8:0]], exp_mem);
      if (er) chk(mem[{a[8], 8'h5A}] == 8'hFF, "R2 sector", mem[{a[8], 8'h5A}], 8'hFF);
      chk(busy_cnt == 0, "R7 done after device finished", busy_cnt, 0);
    end
    chk(width_bad == wb0, "R3 strobe timing", width_bad - wb0, 0);
    @(negedge clk);
    chk(!done, "R10 done pulse", done, 0);
    cfg_stuck = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k;
    rst_n = 0; req_valid = 0; req_erase = 0; req_addr = '0; req_data = '0; poll_mode = '0;
    repeat (4) @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n && !busy && !done, "R10 reset state",
        {fl_ce_n, fl_we_n, fl_oe_n, busy, done}, 5'b11100);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!busy && fl_ce_n, "R10 idle after reset", busy, 0);
    k = 0;
    for (int m = 0; m < 3; m++)
      for (int er = 0; er < 2; er++)
        for (int sc = 0; sc < 4; sc++) begin
          if (!(er == 1 && sc == 3)) begin
            run(er[0], m, sc, 8'(8'h35 + k * 37), AW'(k * 41 + 3));
            k++;
          end
        end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule